// File: doc/BRIEF.md
# Two-Rank Thermal Refresh Scheduler

This block decides when each of two DRAM ranks receives a refresh. A single phase counter marks out the refresh interval. Each rank gets one refresh credit per interval, and the second rank's credit falls half an interval after the first. The block reads a case-temperature code every cycle. When the part runs above 85.0 °C, the interval is halved.

Each rank keeps a count of owed refreshes. It raises a request only while its memory controller reports every bank of that rank precharged. When the controller grants the request, the scheduler drives that rank's active-low chip-select strobe for one cycle. It then holds off further commands to the rank for the refresh cycle time.

The controller may postpone up to eight refreshes. Once eight are owed, an urgent flag tells it to close the rank's banks. The block also tracks self-refresh for each rank. On leaving self-refresh, commands to the rank are held back until the exit delay has expired.

The handshake is request/grant, with `ref_req` acting as valid and `ref_gnt` acting as ready. The grant may be held low for as long as the controller wishes, and the credit stays owed meanwhile. If `bank_idle` falls, the request is withdrawn, because an idle rank is a precondition for the request and not a payload.

Top module: `refresh_sched`

## Requirements
- R1: The refresh interval is TREFI_CYC = floor(TREFI_NS*1000/CLK_PS) clocks while not hot. Rank 0 gains one owed refresh per interval. If the grant is always present, its strobe repeats exactly TREFI_CYC clocks apart.
- R2: `temp_code` is a 12-bit two's-complement value with a resolution of 1/16 °C. `hot_mode` goes high one clock after the code exceeds 1360 (85.0 °C). A code of exactly 1360 counts as cool. While `hot_mode` is high, the interval is TREFI_CYC/2.
- R3: Rank 1's credits fall half an interval after rank 0's, so the two ranks never gain a credit in the same clock. A rank in self-refresh does not shift the other rank's schedule.
- R4: `ref_req[r]` is high only when rank r owes at least one refresh, `bank_idle[r]` is high, and the rank is neither in self-refresh nor in an exit hold. The request is accepted on the edge where `ref_req` and `ref_gnt` are both high. `ref_cs_n[r]` is low for exactly the clock after that edge. After reset, every output is inactive: strobes high, and all other outputs low.
- R5: `cmd_hold[r]` is high for TRFC_CYC = ceil(TRFC_NS*1000/CLK_PS) clocks, starting with the strobe clock. Two strobes to the same rank are never less than TRFC_CYC clocks apart. The request may reopen during the last held clock.
- R6: The owed count saturates at MAX_OWED (8). `ref_urgent[r]` is high exactly while the count equals MAX_OWED. Once the grant returns, a saturated rank drains MAX_OWED back-to-back refreshes spaced TRFC_CYC apart, and no more.
- R7: An accepted `sr_enter[r]` pulse sets `in_sr[r]` on the next clock and clears the owed count. While `in_sr[r]` is high, the rank gains no credits, raises no request and drives no strobe, and `cmd_hold[r]` stays high.
- R8: A `sr_exit[r]` pulse while in self-refresh clears `in_sr[r]`. `cmd_hold[r]` then stays high for TXS_CYC = max(5, ceil((TRFC_NS+10)*1000/CLK_PS)) clocks.
- R9: `sr_enter[r]` is ignored while `cmd_hold[r]` is high, and also in a clock where a refresh is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | TEMP_W | Case temperature, two's complement, 1/16 °C per LSB |
| bank_idle | input | RANKS | High when every bank of the rank is precharged |
| ref_gnt | input | RANKS | Controller accepts the refresh request |
| sr_enter | input | RANKS | Pulse: rank enters self-refresh |
| sr_exit | input | RANKS | Pulse: rank leaves self-refresh |
| ref_req | output | RANKS | Refresh request (valid) |
| ref_urgent | output | RANKS | Owed count has reached its limit |
| ref_cs_n | output | RANKS | Active-low one-clock refresh strobe per rank |
| cmd_hold | output | RANKS | No command may be issued to the rank this clock |
| in_sr | output | RANKS | Rank is in self-refresh |
| hot_mode | output | 1 | Halved refresh interval is in force |

## Verification
The embedded properties are checked on every clock. They cover the following: a request never stands without an idle rank; two accepted refreshes are never closer than the refresh cycle time; the owed count never exceeds its cap; a rank in self-refresh stays silent; leaving self-refresh always starts a hold; the two ranks never gain credit in the same clock. The exact interval lengths, the half-interval stagger, the position of the hot threshold, the drain count after saturation and the length of the exit hold are arithmetic facts about whole schedules. Only the bench's cycle-by-cycle sweeps show these, including a second configuration where the five-clock floor sets the exit hold.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/refsched_phase.sv
// Shared interval phase counter plus temperature decision; emits one
// staggered credit tick per rank.
module refsched_phase #(
  parameter int RANKS     = 2,
  parameter int TREFI_CYC = 6240,
  parameter int TEMP_W    = 12,
  parameter int HOT_LIMIT = 1360
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              hot_mode,
  output logic [RANKS-1:0]  tick
);
  localparam int PW   = (TREFI_CYC > 2) ? $clog2(TREFI_CYC) : 1;
  localparam int HALF = TREFI_CYC / 2;
  localparam logic [PW-1:0] LAST_N = PW'(TREFI_CYC - 1);
  localparam logic [PW-1:0] LAST_H = PW'(HALF - 1);
  localparam logic signed [TEMP_W-1:0] HOT_THR = TEMP_W'(HOT_LIMIT);

  logic [PW-1:0] p_q;
  logic          hot_q;
  logic          wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot_q <= 1'b0;
    else        hot_q <= ($signed(temp_code) > HOT_THR);
  end

  // A switch to the short interval can leave p_q past the new end: wrap.
  assign wrap = hot_q ? (p_q >= LAST_H) : (p_q == LAST_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    p_q <= '0;
    else if (wrap) p_q <= '0;
    else           p_q <= p_q + PW'(1);
  end

  for (genvar r = 0; r < RANKS; r++) begin : g_tick
    localparam logic [PW-1:0] OFS_N = PW'(TREFI_CYC - 1 - (r * TREFI_CYC) / RANKS);
    localparam logic [PW-1:0] OFS_H = PW'(HALF - 1 - (r * HALF) / RANKS);
    assign tick[r] = (p_q == (hot_q ? OFS_H : OFS_N));
  end

  assign hot_mode = hot_q;

  AST_TICK_STAGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tick)); // R3
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hot_q |=> (p_q <= LAST_N)); // R2
endmodule

// File: rtl/refsched_rank.sv
// Per-rank owed counter, request/grant, refresh recovery and
// self-refresh exit hold.
module refsched_rank #(
  parameter int TRFC_CYC = 208,
  parameter int TXS_CYC  = 216,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bank_idle,
  input  logic gnt,
  input  logic sr_enter,
  input  logic sr_exit,
  output logic req,
  output logic urgent,
  output logic cs_n,
  output logic hold,
  output logic in_sr
);
  localparam int RW = $clog2(TRFC_CYC + 1);
  localparam int XW = $clog2(TXS_CYC + 1);
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] OWED_CAP = OW'(MAX_OWED);

  logic [OW-1:0] owed_q;
  logic [RW-1:0] rfc_q;
  logic [XW-1:0] xs_q;
  logic          sr_q;
  logic          cs_n_q;
  logic          accept;
  logic          sr_go;
  logic          sr_leave;

  // Request may open in the final held clock: its command lands after it.
  assign req      = (owed_q != '0) && bank_idle && !sr_q &&
                    (xs_q <= XW'(1)) && (rfc_q <= RW'(1));
  assign accept   = req && gnt;
  assign hold     = sr_q || (rfc_q != '0) || (xs_q != '0);
  assign sr_go    = sr_enter && !sr_q && !hold && !accept;
  assign sr_leave = sr_exit && sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
    end else if (sr_go || sr_q) begin
      owed_q <= '0;
    end else if (tick && !accept && (owed_q != OWED_CAP)) begin
      owed_q <= owed_q + OW'(1);
    end else if (!tick && accept) begin
      owed_q <= owed_q - OW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rfc_q <= '0;
    else if (accept)         rfc_q <= RW'(TRFC_CYC);
    else if (rfc_q != '0)    rfc_q <= rfc_q - RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              xs_q <= '0;
    else if (sr_leave)       xs_q <= XW'(TXS_CYC);
    else if (xs_q != '0)     xs_q <= xs_q - XW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      cs_n_q <= !accept;
      if (sr_go)         sr_q <= 1'b1;
      else if (sr_leave) sr_q <= 1'b0;
    end
  end

  assign urgent = (owed_q == OWED_CAP);
  assign cs_n   = cs_n_q;
  assign in_sr  = sr_q;

  // Checking-only: clocks since the last accepted refresh, saturating.
  logic [RW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_q <= RW'(TRFC_CYC);
    else if (accept)                   gap_q <= RW'(1);
    else if (gap_q < RW'(TRFC_CYC))    gap_q <= gap_q + RW'(1);
  end

  AST_REQ_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> bank_idle); // R4
  AST_RFC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (gap_q >= RW'(TRFC_CYC))); // R5
  AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OWED_CAP); // R6
  AST_SR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q |-> (cs_n && !req && hold)); // R7
  AST_EXIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_q) |-> hold); // R8
  AST_ENTER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !sr_q) |=> !sr_q); // R9
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int RANKS      = 2,
  parameter int CLK_PS     = 1250,
  parameter int TREFI_NS   = 7800,
  parameter int TRFC_NS    = 260,
  parameter int XS_PAD_NS  = 10,
  parameter int XS_MIN_CLK = 5,
  parameter int MAX_OWED   = 8,
  parameter int TEMP_W     = 12,
  parameter int HOT_LIMIT  = 1360
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [RANKS-1:0]  bank_idle,
  input  logic [RANKS-1:0]  ref_gnt,
  input  logic [RANKS-1:0]  sr_enter,
  input  logic [RANKS-1:0]  sr_exit,
  output logic [RANKS-1:0]  ref_req,
  output logic [RANKS-1:0]  ref_urgent,
  output logic [RANKS-1:0]  ref_cs_n,
  output logic [RANKS-1:0]  cmd_hold,
  output logic [RANKS-1:0]  in_sr,
  output logic              hot_mode
);
  // Interval rounds down so the average never stretches; minimums round up.
  localparam int TREFI_CYC = (TREFI_NS * 1000) / CLK_PS;
  localparam int TRFC_CYC  = ceil_div(TRFC_NS * 1000, CLK_PS);
  localparam int TXS_CYC   = max_int(XS_MIN_CLK,
                                     ceil_div((TRFC_NS + XS_PAD_NS) * 1000, CLK_PS));

  logic [RANKS-1:0] tick;

  refsched_phase #(
    .RANKS(RANKS), .TREFI_CYC(TREFI_CYC), .TEMP_W(TEMP_W), .HOT_LIMIT(HOT_LIMIT)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code),
    .hot_mode(hot_mode), .tick(tick)
  );

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    refsched_rank #(
      .TRFC_CYC(TRFC_CYC), .TXS_CYC(TXS_CYC), .MAX_OWED(MAX_OWED)
    ) u_rank (
      .clk(clk), .rst_n(rst_n), .tick(tick[r]),
      .bank_idle(bank_idle[r]), .gnt(ref_gnt[r]),
      .sr_enter(sr_enter[r]), .sr_exit(sr_exit[r]),
      .req(ref_req[r]), .urgent(ref_urgent[r]), .cs_n(ref_cs_n[r]),
      .hold(cmd_hold[r]), .in_sr(in_sr[r])
    );
  end

  AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req & ref_gnt) == '0 |=> ref_cs_n == '1); // R4
endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] temp_code = 12'd400;
  logic [1:0]  bank_idle = 2'b11, ref_gnt = 2'b11, sr_enter = 2'b00, sr_exit = 2'b00;
  logic [1:0]  req0, urg0, cs0, hold0, sr0;
  logic [1:0]  req1, urg1, cs1, hold1, sr1;
  logic        hot0, hot1;

  int checks = 0, errors = 0, n = 0;

  always #5 clk = ~clk;

  // Small timing: interval 80, recovery 6, exit hold 16.
  refresh_sched #(.CLK_PS(1000), .TREFI_NS(80), .TRFC_NS(6)) u0 (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .bank_idle(bank_idle),
    .ref_gnt(ref_gnt), .sr_enter(sr_enter), .sr_exit(sr_exit),
    .ref_req(req0), .ref_urgent(urg0), .ref_cs_n(cs0), .cmd_hold(hold0),
    .in_sr(sr0), .hot_mode(hot0));

  // Five-clock floor on exit hold: interval 80, recovery 1, exit hold 5.
  refresh_sched #(.CLK_PS(4000), .TREFI_NS(320), .TRFC_NS(2)) u1 (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .bank_idle(bank_idle),
    .ref_gnt(ref_gnt), .sr_enter(sr_enter), .sr_exit(sr_exit),
    .ref_req(req1), .ref_urgent(urg1), .ref_cs_n(cs1), .cmd_hold(hold1),
    .in_sr(sr1), .hot_mode(hot1));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, n, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
    n += k;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sr_enter = 2'b00; sr_exit = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset state (R4), cool at the exact threshold (R2 boundary)
    temp_code = 12'd1360; bank_idle = 2'b11; ref_gnt = 2'b11;
    do_reset();
    chk("R4 reset req", req0, 0);
    chk("R4 reset cs_n", cs0, 3);
    chk("R4 reset hold", hold0, 0);
    chk("R4 reset in_sr", sr0, 0);
    chk("R6 reset urgent", urg0, 0);
    chk("R2 reset hot", hot0, 0);

    // Cool schedule sweep: R1 interval, R3 stagger, R4 req, R5 hold
    for (int i = 0; i < 400; i++) begin
      step(1);
      chk("R1 cs rank0", cs0[0], (n >= 81 && n % 80 == 1) ? 0 : 1);
      chk("R3 cs rank1", cs0[1], (n >= 41 && n % 80 == 41) ? 0 : 1);
      chk("R4 req rank0", req0[0], (n >= 80 && n % 80 == 0) ? 1 : 0);
      chk("R4 req rank1", req0[1], (n % 80 == 40) ? 1 : 0);
      chk("R5 hold rank0", hold0[0], (n >= 81 && (n - 81) % 80 < 6) ? 1 : 0);
      chk("R5 hold rank1", hold0[1], (n >= 41 && (n - 41) % 80 < 6) ? 1 : 0);
      chk("R2 hot at 1360", hot0, 0);
    end

    // Hot schedule sweep: R2 halved interval with stagger kept
    temp_code = 12'd1361;
    do_reset();
    for (int i = 0; i < 200; i++) begin
      step(1);
      chk("R2 hot flag", hot0, 1);
      chk("R2 cs rank0 hot", cs0[0], (n >= 41 && n % 40 == 1) ? 0 : 1);
      chk("R3 cs rank1 hot", cs0[1], (n >= 21 && n % 40 == 21) ? 0 : 1);
    end

    // Postponement: R4 no request while busy, R6 saturation and drain
    temp_code = 12'd400; bank_idle = 2'b10;
    do_reset();
    for (int i = 0; i < 801; i++) begin
      step(1);
      chk("R4 req withheld", req0[0], 0);
      if (n == 639) chk("R6 urgent at 7 owed", urg0[0], 0);
      if (n == 640) chk("R6 urgent at 8 owed", urg0[0], 1);
    end
    chk("R6 urgent saturated", urg0[0], 1);
    bank_idle = 2'b11;
    begin
      int cnt = 0;
      for (int i = 0; i < 70; i++) begin
        step(1);
        if (n == 802) chk("R6 urgent cleared", urg0[0], 0);
        chk("R5 drain spacing", cs0[0], (n <= 844 && (n - 802) % 6 == 0) ? 0 : 1);
        if (cs0[0] == 1'b0) cnt++;
      end
      chk("R6 drain count", cnt, 8);
    end

    // Self-refresh: R7 entry, R8 exit hold, R9 entry ignored during hold
    do_reset();
    step(10);
    sr_enter = 2'b01;
    step(1);
    sr_enter = 2'b00;
    chk("R7 in_sr set", sr0[0], 1);
    chk("R7 in_sr set floor cfg", sr1[0], 1);
    begin
      int cnt1 = 0;
      for (int i = 0; i < 199; i++) begin
        step(1);
        chk("R7 silent cs", cs0[0], 1);
        chk("R7 silent req", req0[0], 0);
        chk("R7 hold in sr", hold0[0], 1);
        if (cs0[1] == 1'b0) cnt1++;
      end
      chk("R3 other rank unaffected", cnt1, 3);
    end
    sr_exit = 2'b01;
    step(1);
    sr_exit = 2'b00;
    for (int i = 0; i < 35; i++) begin
      chk("R8 exit hold", hold0[0], (n <= 226 || (n >= 241 && n <= 246)) ? 1 : 0);
      chk("R8 exit hold floor", hold1[0], (n <= 215 || n == 241) ? 1 : 0);
      chk("R1 credits resume", cs0[0], (n == 241) ? 0 : 1);
      if (n >= 216) begin
        chk("R9 entry ignored", sr0[0], 0);
        chk("R9 entry ignored floor", sr1[0], 0);
      end
      if (n == 215) sr_enter = 2'b01;
      step(1);
      sr_enter = 2'b00;
    end

    // Exhaustive threshold sweep over all temperature codes (R2)
    for (int t = 0; t < 4096; t++) begin
      temp_code = 12'(t);
      step(1);
      chk("R2 threshold", hot0, ($signed(12'(t)) > 12'sd1360) ? 1 : 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule